// File: doc/BRIEF.md
# Prioritized Interrupt Recognition Controller

The controller watches three active-low interrupt request lines and decides which one, if any, is offered to the processor and at what priority level. One line always requests level 2. A second line requests a level taken from a 3-bit programmable input, where 0 switches that line off. The third line is the top, non-maskable level 7. Each line is sampled on the falling clock edge and counts as asserted only after two consecutive asserted samples.

The block holds the processor's 3-bit priority mask. A maskable request is offered only when its level is strictly above the mask. The pending level is not latched: the offered request and its level follow the live inputs, so a higher request replaces a lower one that has not yet been taken. The processor takes the offered request by pulsing an acknowledge strobe at an instruction boundary, or when handling of a higher exception ends. The mask then rises to the serviced level. Each maskable line can be set to level-sensitive mode or to edge-detect mode. In edge-detect mode a captured edge stays pending until it is acknowledged.

The level-7 line ignores the mask but responds to transitions only. It raises one request for each new assertion. It raises one more each time the mask falls from 7 to a lower value while the line is still held.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads 7, the pending output is 0 and the pending level reads 0.
- R2: Request lines are active-low and are sampled on falling clock edges. A line counts as asserted only after two consecutive asserted samples, and a single asserted sample is never recognized.
- R3: A maskable request is offered only when its level is strictly greater than the mask. With a mask of 0, every enabled maskable request is offered.
- R4: The fixed line requests level 2. The programmable line requests the level on `prog_lvl_i`, and a value of 0 means that line is never offered.
- R5: The highest recognized level is offered, and it is re-evaluated every cycle from the current inputs. When the two maskable lines present the same level, the fixed line is chosen.
- R6: In level-sensitive mode (`edge_mode_i` bit = 0; bit 0 for the fixed line, bit 1 for the programmable line), a line is offered only while it is qualified asserted and unmasked. A request made while masked leaves nothing behind.
- R7: In edge-detect mode (bit = 1), a qualified assertion edge arriving while that line is unmasked sets a sticky request. The request stays offered after the line is released and is cleared when that line is acknowledged. An edge arriving while the line is masked is forgotten.
- R8: The level-7 line is offered at level 7 whatever the mask value. It raises one request per qualified assertion, and holding the line after acknowledge raises no further request.
- R9: When the mask changes from 7 to any lower value while the level-7 line is qualified asserted, a new level-7 request is raised.
- R10: An acknowledge while a request is offered sets the mask to the offered level at the next clock edge. An acknowledge with nothing offered has no effect. Acknowledge takes precedence over a mask write in the same cycle.
- R11: A mask write (`mask_wr_i`) loads `mask_wdata_i` into the mask at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; requests sampled on its falling edge, state on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_fix_n | input | 1 | Active-low request at the fixed level 2 |
| irq_prog_n | input | 1 | Active-low request at the programmable level |
| irq_top_n | input | 1 | Active-low non-maskable level-7 request |
| prog_lvl_i | input | 3 | Level of the programmable line; 0 disables it |
| edge_mode_i | input | 2 | Per-line mode, 1 = edge-detect; bit 0 fixed, bit 1 programmable |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 3 | Mask value to write |
| ack_i | input | 1 | Acknowledge / take strobe |
| pend_o | output | 1 | A request is offered |
| pend_lvl_o | output | 3 | Level of the offered request, 0 when none |
| mask_o | output | 3 | Current priority mask |

## Verification
If the mask register holds a wrong value, the effect appears at the ports at once. `mask_o` shows it on the cycle after the write or acknowledge. The same combinational path also changes which levels `pend_o` offers. A wrong sticky edge flag or level-7 flag shows up as `pend_o` staying high after an acknowledge, or as a request that never appears once a line has been released. The bench sweeps every mask and programmable level with every combination of the two maskable lines and compares the result with an arithmetic model. A filter fault shows up within one falling edge, as an offer that arrives one sample too early, or one that appears on a single-sample pulse.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_NONE = '0;
    localparam lvl_t LVL_TOP  = '1;

    // request line indices
    localparam int N_SRC    = 3;
    localparam int N_MASKED = 2;
    localparam int IDX_FIX  = 0;
    localparam int IDX_PROG = 1;
    localparam int IDX_TOP  = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FIX  = 2'd1,
        SRC_PROG = 2'd2,
        SRC_TOP  = 2'd3
    } src_e;
endpackage

// File: rtl/irq_sampler.sv
// Falling-edge two-sample qualifier for active-low request lines.
module irq_sampler #(
    parameter int N_LINES = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_n,
    output logic [N_LINES-1:0] qual
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        typedef struct packed {
            logic newer;
            logic older;
        } smp_t;

        smp_t smp_d, smp_q;

        always_comb begin
            smp_d       = smp_q;
            smp_d.newer = ~req_n[g];
            smp_d.older = smp_q.newer;
        end

        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                smp_q <= '0;
            end else begin
                smp_q <= smp_d;
            end
        end

        assign qual[g] = smp_q.newer & smp_q.older;
    end
endmodule

// File: rtl/irq_edge_track.sv
// Per-line level/edge handling for the maskable request lines.
module irq_edge_track #(
    parameter int N_LINES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] qual,
    input  logic [N_LINES-1:0] edge_mode,
    input  logic [N_LINES-1:0] unmasked,
    input  logic [N_LINES-1:0] clr,
    output logic [N_LINES-1:0] active
);
    typedef struct packed {
        logic [N_LINES-1:0] dly;
        logic [N_LINES-1:0] flag;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        trk_d.dly = qual;
        for (int i = 0; i < N_LINES; i++) begin
            if (!edge_mode[i]) begin
                trk_d.flag[i] = 1'b0;
            end else begin
                if (clr[i]) begin
                    trk_d.flag[i] = 1'b0;
                end
                if (qual[i] && !trk_q.dly[i] && unmasked[i]) begin
                    trk_d.flag[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_act
        assign active[g] = edge_mode[g] ? trk_q.flag[g] : qual[g];
    end
endmodule

// File: rtl/irq_arbiter.sv
// Live selection of the offered request; nothing here is latched.
module irq_arbiter
    import irq_prio_pkg::*;
#(
    parameter lvl_t FIX_LEVEL = 3'd2
) (
    input  lvl_t mask,
    input  logic top_req,
    input  logic fix_act,
    input  logic prog_act,
    input  lvl_t prog_lvl,
    output logic fix_open,
    output logic prog_open,
    output logic pend,
    output lvl_t lvl,
    output src_e src
);
    logic fix_ok;
    logic prog_ok;

    always_comb begin
        fix_open  = FIX_LEVEL > mask;
        prog_open = (prog_lvl != LVL_NONE) && (prog_lvl > mask);
        fix_ok    = fix_act && fix_open;
        prog_ok   = prog_act && prog_open;

        pend = 1'b1;
        lvl  = LVL_NONE;
        src  = SRC_NONE;
        if (top_req) begin
            lvl = LVL_TOP;
            src = SRC_TOP;
        end else if (prog_ok && (!fix_ok || prog_lvl > FIX_LEVEL)) begin
            lvl = prog_lvl;
            src = SRC_PROG;
        end else if (fix_ok) begin
            lvl = FIX_LEVEL;
            src = SRC_FIX;
        end else begin
            pend = 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter lvl_t FIX_LEVEL = 3'd2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_fix_n,
    input  logic       irq_prog_n,
    input  logic       irq_top_n,
    input  logic [2:0] prog_lvl_i,
    input  logic [1:0] edge_mode_i,
    input  logic       mask_wr_i,
    input  logic [2:0] mask_wdata_i,
    input  logic       ack_i,
    output logic       pend_o,
    output logic [2:0] pend_lvl_o,
    output logic [2:0] mask_o
);
    typedef struct packed {
        lvl_t mask;
        logic top_dly;
        logic top_flag;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [N_SRC-1:0]    qual_s;
    logic [N_MASKED-1:0] act_s;
    logic [N_MASKED-1:0] open_s;
    logic [N_MASKED-1:0] clr_s;
    logic                fix_open_s;
    logic                prog_open_s;
    logic                pend_s;
    lvl_t                lvl_s;
    src_e                src_s;
    logic                take_s;

    irq_sampler #(.N_LINES(N_SRC)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n ({irq_top_n, irq_prog_n, irq_fix_n}),
        .qual  (qual_s)
    );

    assign open_s[IDX_FIX]  = fix_open_s;
    assign open_s[IDX_PROG] = prog_open_s;
    assign clr_s[IDX_FIX]   = take_s && (src_s == SRC_FIX);
    assign clr_s[IDX_PROG]  = take_s && (src_s == SRC_PROG);

    irq_edge_track #(.N_LINES(N_MASKED)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual      (qual_s[N_MASKED-1:0]),
        .edge_mode (edge_mode_i),
        .unmasked  (open_s),
        .clr       (clr_s),
        .active    (act_s)
    );

    irq_arbiter #(.FIX_LEVEL(FIX_LEVEL)) u_arb (
        .mask      (st_q.mask),
        .top_req   (st_q.top_flag),
        .fix_act   (act_s[IDX_FIX]),
        .prog_act  (act_s[IDX_PROG]),
        .prog_lvl  (prog_lvl_i),
        .fix_open  (fix_open_s),
        .prog_open (prog_open_s),
        .pend      (pend_s),
        .lvl       (lvl_s),
        .src       (src_s)
    );

    assign take_s = ack_i && pend_s;

    always_comb begin
        st_d = st_q;
        if (take_s) begin
            st_d.mask = lvl_s;
        end else if (mask_wr_i) begin
            st_d.mask = mask_wdata_i;
        end

        st_d.top_dly = qual_s[IDX_TOP];

        if (take_s && (src_s == SRC_TOP)) begin
            st_d.top_flag = 1'b0;
        end
        // new assertion, or the mask leaving 7 with the line still held
        if ((qual_s[IDX_TOP] && !st_q.top_dly) ||
            (qual_s[IDX_TOP] && (st_q.mask == LVL_TOP) && (st_d.mask != LVL_TOP))) begin
            st_d.top_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask     <= LVL_TOP;
            st_q.top_dly  <= 1'b0;
            st_q.top_flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o     = pend_s;
    assign pend_lvl_o = lvl_s;
    assign mask_o     = st_q.mask;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack_i,
    input logic       mask_wr_i,
    input logic [2:0] mask_wdata_i,
    input logic       pend_o,
    input logic [2:0] pend_lvl_o,
    input logic [2:0] mask_o,
    input logic [2:0] qual
);
    p_ack_sets_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && pend_o) |=> (mask_o == $past(pend_lvl_o)));

    p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ack_i && pend_o) && !mask_wr_i) |=> $stable(mask_o));

    p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ack_i && pend_o) && mask_wr_i) |=> (mask_o == $past(mask_wdata_i)));

    p_above_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && pend_lvl_o != 3'd7) |-> (pend_lvl_o > mask_o));

    p_level_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> (pend_lvl_o != 3'd0));

    p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_o |-> (pend_lvl_o == 3'd0));

    p_reopen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mask_o) == 3'd7) && (mask_o != 3'd7) && $past(qual[2]))
        |-> (pend_o && pend_lvl_o == 3'd7));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .pend_o       (pend_o),
    .pend_lvl_o   (pend_lvl_o),
    .mask_o       (mask_o),
    .qual         (qual_s)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_fix_n = 1'b1;
    logic       irq_prog_n = 1'b1;
    logic       irq_top_n = 1'b1;
    logic [2:0] prog_lvl_i = 3'd0;
    logic [1:0] edge_mode_i = 2'b00;
    logic       mask_wr_i = 1'b0;
    logic [2:0] mask_wdata_i = 3'd0;
    logic       ack_i = 1'b0;
    logic       pend_o;
    logic [2:0] pend_lvl_o;
    logic [2:0] mask_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_fix_n    (irq_fix_n),
        .irq_prog_n   (irq_prog_n),
        .irq_top_n    (irq_top_n),
        .prog_lvl_i   (prog_lvl_i),
        .edge_mode_i  (edge_mode_i),
        .mask_wr_i    (mask_wr_i),
        .mask_wdata_i (mask_wdata_i),
        .ack_i        (ack_i),
        .pend_o       (pend_o),
        .pend_lvl_o   (pend_lvl_o),
        .mask_o       (mask_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_mask(input int v);
        mask_wr_i = 1'b1;
        mask_wdata_i = 3'(v);
        step(1);
        mask_wr_i = 1'b0;
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        step(1);
        ack_i = 1'b0;
    endtask

    function automatic int exp_lvl(int m, int pl, bit fa, bit pa);
        bit fo = fa && (2 > m);
        bit po = pa && (pl != 0) && (pl > m);
        if (po && (!fo || pl > 2)) return pl;
        if (fo) return 2;
        return 0;
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1 mask", int'(mask_o), 7);
        chk("R1 pend", int'(pend_o), 0);
        chk("R1 lvl", int'(pend_lvl_o), 0);
        rst_n = 1'b1;
        step(2);

        // R3 R4 R5 R6 exhaustive sweep in level mode
        for (int m = 0; m < 8; m++) begin
            set_mask(m);
            chk("R11 mask write", int'(mask_o), m);
            for (int pl = 0; pl < 8; pl++) begin
                for (int k = 0; k < 4; k++) begin
                    int e;
                    prog_lvl_i = 3'(pl);
                    irq_fix_n  = ~k[0];
                    irq_prog_n = ~k[1];
                    step(3);
                    e = exp_lvl(m, pl, k[0], k[1]);
                    chk("R3/R4/R5 sweep lvl", int'(pend_lvl_o), e);
                    chk("R6 sweep pend", int'(pend_o), int'(e != 0));
                end
            end
        end
        irq_fix_n = 1'b1;
        irq_prog_n = 1'b1;
        step(3);

        // R2 filter timing
        set_mask(0);
        irq_fix_n = 1'b0;
        @(negedge clk); #1;
        chk("R2 one sample", int'(pend_o), 0);
        @(negedge clk); #1;
        chk("R2 two samples", int'(pend_o), 1);
        irq_fix_n = 1'b1;
        step(3);
        @(posedge clk); #1;
        irq_fix_n = 1'b0;
        @(posedge clk); #1;
        irq_fix_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk("R2 single sample pulse", int'(pend_o), 0);
        end

        // R5 live re-evaluation
        irq_fix_n = 1'b0;
        step(3);
        chk("R5 fix alone", int'(pend_lvl_o), 2);
        prog_lvl_i = 3'd5;
        irq_prog_n = 1'b0;
        step(3);
        chk("R5 higher replaces", int'(pend_lvl_o), 5);
        prog_lvl_i = 3'd1;
        step(1);
        chk("R5 falls back", int'(pend_lvl_o), 2);
        irq_prog_n = 1'b1;
        irq_fix_n = 1'b1;
        step(3);

        // R6 masked request leaves nothing
        set_mask(5);
        irq_fix_n = 1'b0;
        step(3);
        irq_fix_n = 1'b1;
        step(3);
        set_mask(0);
        chk("R6 no trace", int'(pend_o), 0);

        // R10 idle acknowledge and ack vs write
        do_ack();
        chk("R10 idle ack", int'(mask_o), 0);
        irq_fix_n = 1'b0;
        step(3);
        mask_wr_i = 1'b1;
        mask_wdata_i = 3'd6;
        do_ack();
        mask_wr_i = 1'b0;
        chk("R10 ack beats write", int'(mask_o), 2);
        chk("R10 fix now masked", int'(pend_o), 0);
        irq_fix_n = 1'b1;
        step(3);

        // R7 edge mode on the fixed line
        edge_mode_i = 2'b01;
        set_mask(0);
        irq_fix_n = 1'b0;
        step(3);
        chk("R7 edge pend", int'(pend_lvl_o), 2);
        irq_fix_n = 1'b1;
        step(3);
        chk("R7 sticky", int'(pend_o), 1);
        do_ack();
        chk("R7 ack mask", int'(mask_o), 2);
        set_mask(0);
        chk("R7 cleared", int'(pend_o), 0);
        set_mask(3);
        irq_fix_n = 1'b0;
        step(3);
        set_mask(0);
        chk("R7 held no edge", int'(pend_o), 0);
        irq_fix_n = 1'b1;
        step(3);
        chk("R7 masked edge forgotten", int'(pend_o), 0);
        // edge mode on the programmable line
        edge_mode_i = 2'b10;
        prog_lvl_i = 3'd4;
        irq_prog_n = 1'b0;
        step(3);
        irq_prog_n = 1'b1;
        step(3);
        chk("R7 prog sticky", int'(pend_lvl_o), 4);
        do_ack();
        chk("R7 prog ack mask", int'(mask_o), 4);
        chk("R7 prog cleared", int'(pend_o), 0);
        edge_mode_i = 2'b00;

        // R8 level-7 line
        set_mask(7);
        irq_top_n = 1'b0;
        step(3);
        chk("R8 top offered", int'(pend_lvl_o), 7);
        do_ack();
        chk("R8 ack mask", int'(mask_o), 7);
        step(4);
        chk("R8 once per assertion", int'(pend_o), 0);

        // R9 mask drop while held
        set_mask(3);
        chk("R9 reopen pend", int'(pend_o), 1);
        chk("R9 reopen lvl", int'(pend_lvl_o), 7);
        do_ack();
        chk("R9 ack mask", int'(mask_o), 7);
        irq_top_n = 1'b1;
        step(3);
        set_mask(2);
        chk("R9 released no reopen", int'(pend_o), 0);
        irq_top_n = 1'b0;
        step(3);
        chk("R8 new assertion unmasked", int'(pend_lvl_o), 7);
        do_ack();
        irq_top_n = 1'b1;
        step(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule